// File: doc/BRIEF.md
# Seed-Switching Scrambled Test Pattern Generator

This block produces an endless stream of 66-bit data blocks for link stress testing. Each block carries a fixed 2-bit sync header and a 64-bit payload. The payload is a constant programmable data word passed through a 58-bit self-synchronizing scrambler with polynomial 1 + x^39 + x^58.

A segment timer counts blocks and walks through four phases in a fixed loop. The phases use seed A, the bitwise inverse of seed A, seed B and the inverse of seed B. On the first block of every segment the scrambler state is forced to the seed for the new phase. In the two inverse phases the data word is also inverted before scrambling.

A receiver with a free-running descrambler loses lock only in the first block after each reseed. Every later block in the segment descrambles back to the phase data. Deasserting enable puts the generator back at the start of the seed A phase.

Top module: `tpg_seed_switch`

## Requirements
- R1: Every valid block has `blk_out[1:0] = 2'b01`. Scrambled payload bit i is placed at `blk_out[2+i]`, and bit 0 is the first bit scrambled.
- R2: Each scrambled bit equals the data bit XOR the scrambled bits produced 39 and 58 bits earlier. The scrambler history runs on from one block to the next within a segment.
- R3: The phases repeat in the order seed A, ~seed A, seed B, ~seed B. On the first block of a phase the history is replaced by that phase's seed. Seed bit j stands for the scrambled bit produced j+1 bits earlier, so bit 38 and bit 57 are the two taps.
- R4: The data word is scrambled as given in the seed A and seed B phases. It is scrambled bitwise inverted in the two inverse phases.
- R5: A segment lasts `seg_len` blocks, and a value of 0 is treated as 1. The value is compared against the running block count on every block.
- R6: `seg_start` is high together with the first block of each segment and low on every other block.
- R7: A block appears at the outputs one clock edge after `enable` is sampled high. `blk_valid` is high on exactly those cycles.
- R8: When `enable` is sampled low, `blk_valid` and `seg_start` go low. The next enabled block starts a new seed A segment.
- R9: A self-synchronizing descrambler that runs across the stream recovers the phase data word (inverted in inverse phases) in every block of a segment except its first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generate one block per clock while high |
| seed_a | input | 58 | First programmable scrambler seed |
| seed_b | input | 58 | Second programmable scrambler seed |
| data_word | input | 64 | Constant payload before scrambling |
| seg_len | input | 16 | Segment length in blocks (0 acts as 1) |
| blk_out | output | 66 | Header in [1:0], scrambled payload in [65:2] |
| blk_valid | output | 1 | blk_out holds a new block |
| seg_start | output | 1 | Current block is the first of a segment |

## Verification
The embedded assertions check the following on every cycle:
- the sync header of each valid block;
- that the phase only moves at a segment boundary;
- that a restart begins in the seed A phase;
- that `seg_start` never appears without a valid block;
- that a unit-length segment flags every block.

The payload values need the bench's scenarios. These are:
- comparison against an independent scrambler model across short, unit and zero segment lengths;
- a mid-segment disable and restart;
- a running descrambler that shows the data recovered after each reseed.

// File: rtl/tpg_pkg.sv
// Shared constants and types for the seed-switching pattern generator.
// Assumes the 1 + x^39 + x^58 scrambler and 66-bit blocks.
package tpg_pkg;
    localparam int SCR_W  = 58;
    localparam int PAY_W  = 64;
    localparam int HDR_W  = 2;
    localparam int BLK_W  = PAY_W + HDR_W;
    localparam int TAP_LO = 39;
    localparam int TAP_HI = 58;
    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;

    // Phase order is behaviour: the timer walks these in ascending order.
    typedef enum logic [1:0] {
        PH_A     = 2'd0,
        PH_A_INV = 2'd1,
        PH_B     = 2'd2,
        PH_B_INV = 2'd3
    } phase_e;
endpackage

// File: rtl/tpg_seg_timer.sv
// Segment timer: counts blocks within a segment and steps the seed phase.
// Assumes one block per enabled cycle. A seg_len of 0 acts as 1.
module tpg_seg_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] seg_len,
    output tpg_pkg::phase_e  phase,
    output logic             at_first
);
    import tpg_pkg::*;

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_eff;
    phase_e           phase_q;

    // Effective length clamps zero up to one.
    always_comb len_eff = (seg_len == '0) ? {{(LEN_W-1){1'b0}}, 1'b1} : seg_len;

    // Block counter and phase stepper; disable returns to the seed A start.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q   <= '0;
            phase_q <= PH_A;
        end else if (cnt_q >= len_eff - 1'b1) begin
            cnt_q   <= '0;
            phase_q <= phase_e'(phase_q + 2'd1);
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase    = phase_q;
    assign at_first = (cnt_q == '0);

    // R3: the phase changes only at the start of a segment
    a_r3_phase_moves_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> at_first);

    // R8: a disabled cycle leaves the timer at the seed A start
    a_r8_restart_at_seed_a: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase_q == PH_A && at_first));

    // R5: a unit-length segment makes every block a first block
    a_r5_unit_segment: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && seg_len <= 1) |=> at_first);
endmodule

// File: rtl/tpg_scrambler.sv
// Self-synchronizing scrambler: processes one 64-bit word per advance.
// The history can be overwritten by a seed in the same cycle it is used.
// State bit j holds the scrambled bit produced j+1 bits ago.
module tpg_scrambler #(
    parameter int SW = tpg_pkg::SCR_W,
    parameter int PW = tpg_pkg::PAY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          load,
    input  logic [SW-1:0] seed_val,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    import tpg_pkg::*;

    logic [SW-1:0] hist_q;
    logic [SW-1:0] hist_nxt;
    logic [PW-1:0] pay_nxt;

    // Bit-serial scramble of one word, bit 0 first, from seed or history.
    always_comb begin
        logic [SW-1:0] h;
        logic          b;
        h = load ? seed_val : hist_q;
        for (int i = 0; i < PW; i++) begin
            b          = din[i] ^ h[TAP_LO-1] ^ h[TAP_HI-1];
            pay_nxt[i] = b;
            h          = {h[SW-2:0], b};
        end
        hist_nxt = h;
    end

    // History and output word registers, updated once per block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            dout   <= '0;
        end else if (advance) begin
            hist_q <= hist_nxt;
            dout   <= pay_nxt;
        end
    end
endmodule

// File: rtl/tpg_seed_switch.sv
// Top: seed-switching scrambled pattern generator.
// Picks the seed and data polarity for the current phase. Drives the scrambler
// and registers the 66-bit block with its valid and segment-start flags.
// Assumes the seeds and data_word are held stable while enabled.
module tpg_seed_switch #(
    parameter int LEN_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [tpg_pkg::SCR_W-1:0] seed_a,
    input  logic [tpg_pkg::SCR_W-1:0] seed_b,
    input  logic [tpg_pkg::PAY_W-1:0] data_word,
    input  logic [LEN_W-1:0]          seg_len,
    output logic [tpg_pkg::BLK_W-1:0] blk_out,
    output logic                      blk_valid,
    output logic                      seg_start
);
    import tpg_pkg::*;

    phase_e           phase;
    logic             at_first;
    logic             invert;
    logic [SCR_W-1:0] seed_sel;
    logic [PAY_W-1:0] data_sel;
    logic [PAY_W-1:0] payload;

    tpg_seg_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .seg_len  (seg_len),
        .phase    (phase),
        .at_first (at_first)
    );

    // Seed and data polarity for the current phase.
    always_comb begin
        invert   = (phase == PH_A_INV) || (phase == PH_B_INV);
        seed_sel = (phase == PH_A || phase == PH_A_INV) ? seed_a : seed_b;
        if (invert) seed_sel = ~seed_sel;
        data_sel = invert ? ~data_word : data_word;
    end

    tpg_scrambler #(.SW(SCR_W), .PW(PAY_W)) u_scr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (enable),
        .load     (at_first),
        .seed_val (seed_sel),
        .din      (data_sel),
        .dout     (payload)
    );

    // Output flags, aligned with the registered payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_valid <= 1'b0;
            seg_start <= 1'b0;
        end else begin
            blk_valid <= enable;
            seg_start <= enable && at_first;
        end
    end

    assign blk_out = {payload, HDR_DATA};

    // R1: every valid block carries the data sync header
    a_r1_header: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_out[1:0] == 2'b01));

    // R6: segment start never appears without a valid block
    a_r6_start_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |-> blk_valid);

    // R8: the first block after a restart opens a segment
    a_r8_restart_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_valid) |-> seg_start);
endmodule

// File: tb/tpg_seed_switch_test.sv
`timescale 1ns/1ps
module tpg_seed_switch_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [57:0]   seed_a = 58'h2A5_1234_5678_9ABC;
    logic [57:0]   seed_b = 58'h0F0_0FED_CBA9_8765;
    logic [63:0]   data_word = 64'h0000_0000_0000_0000;
    logic [15:0]   seg_len = 16'd3;
    logic [65:0]   blk_out;
    logic          blk_valid;
    logic          seg_start;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench reference model state
    int          m_cnt = 0;
    int          m_phase = 0;
    logic [57:0] m_hist = '0;
    logic [63:0] m_data;
    logic [57:0] rx_hist = '0;

    always #4 clk = ~clk;

    tpg_seed_switch uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .seed_a(seed_a), .seed_b(seed_b), .data_word(data_word),
        .seg_len(seg_len), .blk_out(blk_out), .blk_valid(blk_valid),
        .seg_start(seg_start)
    );

    task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0;
        m_phase = 0;
    endtask

    // expected next block from the requirements (R1-R5)
    task automatic model_next(output logic [65:0] exp, output bit first);
        logic [57:0] s;
        logic [63:0] d;
        logic [63:0] p;
        logic        b;
        int          len;
        first = (m_cnt == 0);
        case (m_phase)
            0: s = seed_a;
            1: s = ~seed_a;
            2: s = seed_b;
            default: s = ~seed_b;
        endcase
        if (!first) s = m_hist;
        d = m_phase[0] ? ~data_word : data_word;
        m_data = d;
        for (int i = 0; i < 64; i++) begin
            b    = d[i] ^ s[38] ^ s[57];
            p[i] = b;
            s    = {s[56:0], b};
        end
        m_hist = s;
        exp = {p, 2'b01};
        len = (seg_len == 0) ? 1 : int'(seg_len);
        if (m_cnt + 1 >= len) begin
            m_cnt = 0;
            m_phase = (m_phase + 1) % 4;
        end else begin
            m_cnt++;
        end
    endtask

    // enable for n blocks, compare each; leaves enable low at return
    task automatic run_blocks(input int n, input string tag, input bit descr);
        logic [65:0] exp;
        bit          first;
        logic [63:0] rec;
        logic        r;
        @(negedge clk);
        enable = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            model_next(exp, first);
            check(blk_valid === 1'b1, {tag, " R7 valid"}, {65'b0, blk_valid}, 66'd1);
            check(blk_out === exp, {tag, " R1 R2 R3 R4 block"}, blk_out, exp);
            check(seg_start === first, {tag, " R5 R6 seg_start"}, {65'b0, seg_start}, {65'b0, first});
            if (descr) begin
                for (int i = 0; i < 64; i++) begin
                    r = blk_out[2+i];
                    rec[i] = r ^ rx_hist[38] ^ rx_hist[57];
                    rx_hist = {rx_hist[56:0], r};
                end
                if (!first)
                    check(rec === m_data, {tag, " R9 descrambled"}, {2'b0, rec}, {2'b0, m_data});
            end
        end
        enable = 1'b0;
        model_reset();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(blk_valid === 1'b0 && seg_start === 1'b0, "R7 reset idle",
              {64'b0, blk_valid, seg_start}, 66'd0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic t_short_segments();
        seg_len = 16'd3;
        data_word = 64'hDEAD_BEEF_0123_4567;
        run_blocks(14, "short", 1'b0);
    endtask

    task automatic t_unit_and_zero();
        seg_len = 16'd1;
        run_blocks(6, "unit", 1'b0);
        seg_len = 16'd0;
        data_word = 64'h0;
        run_blocks(6, "zero", 1'b0);
    endtask

    task automatic t_disable_midway();
        seg_len = 16'd5;
        data_word = 64'hFFFF_0000_A5A5_5A5A;
        run_blocks(7, "pre-stop", 1'b0);
        @(negedge clk);
        check(blk_valid === 1'b0 && seg_start === 1'b0, "R8 stopped",
              {64'b0, blk_valid, seg_start}, 66'd0);
        run_blocks(3, "restart R8", 1'b0);
    endtask

    task automatic t_descramble();
        seg_len = 16'd4;
        data_word = 64'h1357_9BDF_2468_ACE0;
        rx_hist = '0;
        run_blocks(20, "rx", 1'b1);
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_short_segments();
        t_unit_and_zero();
        t_disable_midway();
        t_descramble();
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule